// File: doc/BRIEF.md
# Shared Address/Data Bus Memory Target

This block is the responding side of a 32-bit synchronous bus on which address and data travel over the same wires, one after the other. It watches for the start of a transaction, decodes the command nibble and the address, and claims the transaction only for memory reads and memory writes that fall inside one configured window. Inside that window sits a small local register file of 32-bit words.

Once it has claimed a transaction, the target runs data phases. In each phase the four command lines act as active-low byte enables. A word moves only in a clock where both the initiator and the target signal ready. The target tracks the word address through a burst, and it disconnects when a burst reaches a parameterised length or reaches the last word of the window. It produces even parity for the data it drives and checks the parity the initiator drives. It is placed behind the bus pads, with every outgoing bus signal split into a value and an enable.

Top module: `pbus_target`

## Requirements
- R1: While reset is held, devsel_n_o, trdy_n_o and stop_n_o are 1, ad_oe and par_oe are 0, and par_err_o is 0. Every register word resets to 0.
- R2: An address phase is the first clock with frame_n_i at 0 after a clock with frame_n_i at 1 while the target is idle. It is claimed when cbe_n_i is 4'b0110 (memory read) or 4'b0111 (memory write) and ad_i lies in [BASE_ADDR, BASE_ADDR + 4*REG_WORDS), with ad_i[1:0] ignored. devsel_n_o is then 0 from the next clock until release.
- R3: Any other command value, including reserved ones, or an address outside the window, leaves devsel_n_o, trdy_n_o and stop_n_o at 1 and ad_oe at 0, and changes no register word.
- R4: For a claimed write, trdy_n_o is 0 from the clock after the address phase. In a clock with irdy_n_i and trdy_n_o both 0, byte lane i (bits 8i+7..8i) of the current word takes ad_i when cbe_n_i[i] is 0 and keeps its value when cbe_n_i[i] is 1.
- R5: For a claimed read, the clock after the address phase is a turnaround clock: devsel_n_o is 0, trdy_n_o is 1 and ad_oe is 0. From then on trdy_n_o is 0, ad_oe is 1 and ad_o shows the full current word, whatever the byte enables are.
- R6: A clock with irdy_n_i at 1 moves no data. The target keeps trdy_n_o, stop_n_o and ad_o unchanged, and no register word changes.
- R7: The first word is index ad_i[IDX_W+1:2] of the address phase. Each completed data phase advances the word by one, which is an address step of 4.
- R8: stop_n_o is 0 together with trdy_n_o on a data phase that is the MAX_BURST-th of the transaction or that addresses word REG_WORDS-1. If that phase completes with frame_n_i still at 0, the following clocks show trdy_n_o 1, stop_n_o 0 and devsel_n_o 0 until frame_n_i is sampled at 1. The target is then idle.
- R9: A completed data phase with frame_n_i at 1 ends the transaction. In the next clock devsel_n_o, trdy_n_o and stop_n_o are 1 and ad_oe is 0.
- R10: In the clock after every clock with ad_oe at 1, par_oe is 1 and par_o equals the XOR of ad_o and cbe_n_i of that earlier clock. This makes the 37 bits even. Otherwise par_oe is 0.
- R11: par_i is compared in the clock after each address phase and after each completed write data phase. The expected value is the XOR of ad_i and cbe_n_i of the covered clock. A mismatch sets par_err_o one clock later, and par_err_o stays at 1 until reset. par_i in any other clock is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | Initiator transaction frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| cbe_n_i | input | 4 | Command in the address phase, active-low byte enables in data phases |
| ad_i | input | 32 | Shared address/data lines as received |
| ad_o | output | 32 | Read data driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for ad_o |
| devsel_n_o | output | 1 | Transaction claimed, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| stop_n_o | output | 1 | Target termination request, active low |
| par_i | input | 1 | Parity driven by the initiator |
| par_o | output | 1 | Parity for the target's read data |
| par_oe | output | 1 | Drive enable for par_o |
| par_err_o | output | 1 | Sticky parity mismatch flag |

## Verification
The burst-length disconnect and the initiator's own final phase can land on the same data phase. In that case the target raises stop_n_o at the moment the initiator lifts frame_n_i. This is provoked with bursts of exactly MAX_BURST words and with single transfers that hit the last word of the window. It is judged by requiring a plain release in the next clock, with no back-off clock. Random bursts with initiator wait states move the coincidence across different phases, and each one is compared against a bench model of the stop position and of the register contents.

// File: rtl/pbus_target_pkg.sv
package pbus_target_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_DATA,
    ST_RD_TURN,
    ST_RD_DATA,
    ST_BACKOFF
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_READ  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

  // even parity bit over the shared lines and the command/enable nibble
  function automatic logic even_parity(input logic [31:0] ad, input logic [3:0] cbe);
    return ^{ad, cbe};
  endfunction

  // replace the byte lanes whose active-low enable is 0
  function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                             input logic [31:0] nxt,
                                             input logic [3:0]  be_n);
    logic [31:0] res;
    res = cur;
    for (int ln = 0; ln < 4; ln++) begin
      if (!be_n[ln]) res[8*ln +: 8] = nxt[8*ln +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/pbus_addr_decode.sv
module pbus_addr_decode
  import pbus_target_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h8000_1000,
  parameter int          REG_WORDS = 16
) (
  input  logic [31:0]                   ad,
  input  logic [3:0]                    cmd,
  output logic                          hit,
  output logic                          is_write,
  output logic [$clog2(REG_WORDS)-1:0]  word_idx
);
  localparam int          IDX_W    = $clog2(REG_WORDS);
  localparam logic [31:0] WIN_MASK = ~(32'(REG_WORDS * 4) - 32'd1);

  logic cmd_ok;
  logic in_win;

  assign cmd_ok   = (cmd == CMD_MEM_READ) || (cmd == CMD_MEM_WRITE);
  assign in_win   = (ad & WIN_MASK) == BASE_ADDR;
  assign hit      = cmd_ok && in_win;
  assign is_write = (cmd == CMD_MEM_WRITE);
  assign word_idx = ad[2 +: IDX_W];
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile
  import pbus_target_pkg::*;
#(
  parameter int REG_WORDS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(REG_WORDS)-1:0]  idx,
  input  logic [31:0]                   wdata,
  input  logic [3:0]                    wbe_n,
  output logic [31:0]                   rdata
);
  localparam int IDX_W = $clog2(REG_WORDS);

  logic [31:0] words [REG_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < REG_WORDS; w++) words[w] <= '0;
    end else if (we) begin
      for (int w = 0; w < REG_WORDS; w++) begin
        if (idx == IDX_W'(w)) words[w] <= lane_merge(words[w], wdata, wbe_n);
      end
    end
  end

  assign rdata = words[idx];
endmodule

// File: rtl/pbus_parity.sv
module pbus_parity
  import pbus_target_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_in,
  input  logic        chk_en,
  input  logic        par_in,
  input  logic [31:0] ad_out,
  input  logic        out_en,
  output logic        par_out,
  output logic        par_out_en,
  output logic        mismatch,
  output logic        par_err
);
  logic exp_q;
  logic chk_q;

  assign mismatch = chk_q && (par_in != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q      <= 1'b0;
      chk_q      <= 1'b0;
      par_out    <= 1'b0;
      par_out_en <= 1'b0;
      par_err    <= 1'b0;
    end else begin
      exp_q      <= even_parity(ad_in, cbe_in);
      chk_q      <= chk_en;
      par_out    <= even_parity(ad_out, cbe_in);
      par_out_en <= out_en;
      if (mismatch) par_err <= 1'b1;
    end
  end
endmodule

// File: rtl/pbus_target.sv
module pbus_target
  import pbus_target_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h8000_1000,
  parameter int          REG_WORDS = 16,
  parameter int          MAX_BURST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n_i,
  input  logic        irdy_n_i,
  input  logic [3:0]  cbe_n_i,
  input  logic [31:0] ad_i,
  output logic [31:0] ad_o,
  output logic        ad_oe,
  output logic        devsel_n_o,
  output logic        trdy_n_o,
  output logic        stop_n_o,
  input  logic        par_i,
  output logic        par_o,
  output logic        par_oe,
  output logic        par_err_o
);
  localparam int IDX_W = $clog2(REG_WORDS);
  localparam int CNT_W = $clog2(MAX_BURST) + 1;

  tgt_state_e        state_q, state_d;
  logic              frame_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;

  logic              dec_hit, dec_wr;
  logic [IDX_W-1:0]  dec_idx;

  // named events for the checker
  logic addr_phase;
  logic data_state;
  logic last_phase;
  logic xfer;
  logic wr_xfer;
  logic par_mismatch;
  logic [31:0] rd_word;

  pbus_addr_decode #(.BASE_ADDR(BASE_ADDR), .REG_WORDS(REG_WORDS)) u_dec (
    .ad(ad_i), .cmd(cbe_n_i), .hit(dec_hit), .is_write(dec_wr), .word_idx(dec_idx)
  );

  assign addr_phase = (state_q == ST_IDLE) && !frame_n_i && frame_q;
  assign data_state = (state_q == ST_WR_DATA) || (state_q == ST_RD_DATA);
  assign last_phase = data_state &&
                      ((cnt_q == CNT_W'(MAX_BURST - 1)) || (idx_q == IDX_W'(REG_WORDS - 1)));
  assign xfer       = data_state && !irdy_n_i;
  assign wr_xfer    = xfer && (state_q == ST_WR_DATA);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (addr_phase && dec_hit) state_d = dec_wr ? ST_WR_DATA : ST_RD_TURN;
      ST_RD_TURN: state_d = ST_RD_DATA;
      ST_WR_DATA, ST_RD_DATA: begin
        if (xfer) begin
          if (frame_n_i)       state_d = ST_IDLE;
          else if (last_phase) state_d = ST_BACKOFF;
        end
      end
      ST_BACKOFF: if (frame_n_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= 1'b1;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_n_i;
      if (addr_phase) begin
        idx_q <= dec_idx;
        cnt_q <= '0;
      end else if (xfer) begin
        idx_q <= idx_q + IDX_W'(1);
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  pbus_regfile #(.REG_WORDS(REG_WORDS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_xfer), .idx(idx_q),
    .wdata(ad_i), .wbe_n(cbe_n_i), .rdata(rd_word)
  );

  assign ad_o       = rd_word;
  assign ad_oe      = (state_q == ST_RD_DATA);
  assign devsel_n_o = (state_q == ST_IDLE);
  assign trdy_n_o   = !data_state;
  assign stop_n_o   = !(last_phase || (state_q == ST_BACKOFF));

  pbus_parity u_par (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_i), .cbe_in(cbe_n_i),
    .chk_en(addr_phase || wr_xfer), .par_in(par_i),
    .ad_out(ad_o), .out_en(ad_oe),
    .par_out(par_o), .par_out_en(par_oe), .mismatch(par_mismatch), .par_err(par_err_o)
  );
endmodule

// File: rtl/pbus_target_chk.sv
module pbus_target_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_n_i,
  input logic irdy_n_i,
  input logic [3:0] cbe_n_i,
  input logic addr_phase,
  input logic dec_hit,
  input logic xfer,
  input logic par_mismatch,
  input logic devsel_n_o,
  input logic trdy_n_o,
  input logic stop_n_o,
  input logic ad_oe,
  input logic par_oe,
  input logic par_err_o
);
  assert_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && dec_hit |=> !devsel_n_o);

  assert_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && !dec_hit |=> devsel_n_o && trdy_n_o && stop_n_o && !ad_oe);

  assert_ready_claimed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n_o |-> !devsel_n_o);

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase && dec_hit && !cbe_n_i[0] |=> trdy_n_o && !devsel_n_o && !ad_oe);

  assert_wait_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n_o && irdy_n_i |=> !trdy_n_o && $stable(stop_n_o));

  assert_backoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && !frame_n_i && !stop_n_o |=> trdy_n_o && !stop_n_o && !devsel_n_o);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer && frame_n_i |=> devsel_n_o && trdy_n_o && stop_n_o && !ad_oe);

  assert_par_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> par_oe);

  assert_par_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    par_mismatch |=> par_err_o);

  assert_par_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_o |=> par_err_o);
endmodule

bind pbus_target pbus_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i),
  .cbe_n_i(cbe_n_i), .addr_phase(addr_phase), .dec_hit(dec_hit), .xfer(xfer),
  .par_mismatch(par_mismatch), .devsel_n_o(devsel_n_o), .trdy_n_o(trdy_n_o),
  .stop_n_o(stop_n_o), .ad_oe(ad_oe), .par_oe(par_oe), .par_err_o(par_err_o)
);

// File: tb/sim_pbus_target.sv
module sim_pbus_target;
  localparam logic [31:0] BASE = 32'h8000_1000;
  localparam int NW = 16;
  localparam int MB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_d = 1'b1, irdy_d = 1'b1, par_d = 1'b0;
  logic [3:0]  cbe_d = 4'h0;
  logic [31:0] ad_d = 32'h0;
  logic [31:0] ad_o;
  logic ad_oe, devsel_n, trdy_n, stop_n, par_o, par_oe, par_err;

  int nchk = 0, nfail = 0;
  bit exp_err = 0, err_armed = 0, chk_next = 0, flip_next = 0;
  logic [31:0] shadow [NW];

  always #2 clk = ~clk;

  pbus_target #(.BASE_ADDR(BASE), .REG_WORDS(NW), .MAX_BURST(MB)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n_i(frame_d), .irdy_n_i(irdy_d), .cbe_n_i(cbe_d),
    .ad_i(ad_d), .ad_o(ad_o), .ad_oe(ad_oe), .devsel_n_o(devsel_n), .trdy_n_o(trdy_n),
    .stop_n_o(stop_n), .par_i(par_d), .par_o(par_o), .par_oe(par_oe), .par_err_o(par_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] cur, input logic [31:0] nw, input logic [3:0] be_n);
    logic [31:0] m;
    m = {{8{~be_n[3]}}, {8{~be_n[2]}}, {8{~be_n[1]}}, {8{~be_n[0]}}};
    return (cur & ~m) | (nw & m);
  endfunction

  function automatic bit exp_claim(input logic [3:0] cmd, input logic [31:0] a);
    return (cmd == 4'b0110 || cmd == 4'b0111) && (a >= BASE) && (a < BASE + 32'(NW * 4));
  endfunction

  function automatic logic [3:0] st_bits();
    return {devsel_n, trdy_n, stop_n, ad_oe};
  endfunction

  // one clock: inputs already driven; sample 1 ns after the edge
  task automatic step();
    logic p, po_exp, prev_oe, pend;
    p = ^{ad_d, cbe_d};
    po_exp = ^{ad_o, cbe_d};
    prev_oe = ad_oe;
    pend = err_armed;
    @(posedge clk);
    #1;
    if (pend) exp_err = 1;
    err_armed = chk_next && flip_next;
    par_d = p ^ flip_next;
    flip_next = 0;
    chk_next = 0;
    if (prev_oe) check(par_oe === 1'b1 && par_o === po_exp, "R10 parity out", {par_oe, par_o}, {1'b1, po_exp});
    else         check(par_oe === 1'b0, "R10 parity idle", par_oe, 0);
    check(par_err === exp_err, "R11 error flag", par_err, exp_err);
  endtask

  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input int n, input int wait_pct,
                     input logic [3:0] be_fix, input bit be_rand, input bit flip_addr, input bit flip_data);
    bit claim, wr, fin, first, exp_stop, waited, last;
    int idx, phase;
    logic [3:0] be;
    logic [31:0] dat;
    claim = exp_claim(cmd, addr);
    wr = (cmd == 4'b0111);
    idx = int'(addr[5:2]);
    phase = 0; fin = 0; first = 1; waited = 0;
    frame_d = 0; irdy_d = 1; ad_d = addr; cbe_d = cmd;
    chk_next = 1; flip_next = flip_addr;
    step();
    if (!claim) begin
      for (int k = 0; k < n; k++) begin
        check(st_bits() == 4'b1110, "R3 not claimed", st_bits(), 4'b1110);
        irdy_d = 0; frame_d = (k == n - 1); ad_d = $urandom; cbe_d = 4'h0;
        step();
      end
      check(st_bits() == 4'b1110, "R3 stays idle", st_bits(), 4'b1110);
    end else begin
      check(devsel_n == 1'b0, "R2 claim", devsel_n, 0);
      while (!fin) begin
        if (first && !wr) begin
          check(trdy_n == 1'b1 && ad_oe == 1'b0, "R5 turnaround", {trdy_n, ad_oe}, 2'b10);
          irdy_d = 1; frame_d = 0; ad_d = 0; cbe_d = be_fix;
          first = 0;
          step();
        end else begin
          first = 0;
          exp_stop = (phase == MB - 1) || (idx == NW - 1);
          check(!devsel_n && !trdy_n, waited ? "R6 held ready" : (wr ? "R4 write ready" : "R5 read ready"),
                {devsel_n, trdy_n}, 2'b00);
          check(stop_n == !exp_stop, "R8 stop position", stop_n, !exp_stop);
          if (!wr) check(ad_oe && ad_o == shadow[idx], "R7 read word", ad_o, shadow[idx]);
          be = be_rand ? 4'($urandom) : be_fix;
          dat = $urandom;
          waited = ($urandom % 100) < wait_pct;
          cbe_d = be; ad_d = wr ? dat : 32'h0;
          if (waited) begin
            irdy_d = 1; frame_d = 0;
            step();
          end else begin
            last = (phase == n - 1);
            irdy_d = 0; frame_d = last;
            if (wr) begin chk_next = 1; flip_next = flip_data && (phase == 0); end
            step();
            if (wr) shadow[idx] = merge(shadow[idx], dat, be);
            phase++;
            idx = (idx + 1) % NW;
            if (last) fin = 1;
            else if (exp_stop) begin
              check(trdy_n && !stop_n && !devsel_n, "R8 backoff", {devsel_n, trdy_n, stop_n}, 3'b010);
              frame_d = 1; irdy_d = 0; ad_d = 0;
              step();
              fin = 1;
            end
          end
        end
      end
      check(st_bits() == 4'b1110, "R9 release", st_bits(), 4'b1110);
    end
    irdy_d = 1; frame_d = 1;
    step();
  endtask

  task automatic read_all();
    for (int w = 0; w < NW; w += MB) txn(4'b0110, BASE + 32'(w * 4), MB, 0, 4'h0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < NW; w++) shadow[w] = 32'h0;
    #1;
    check(st_bits() == 4'b1110 && !par_oe && !par_err, "R1 reset outputs", {st_bits(), par_oe, par_err}, 6'b111000);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    read_all();                                              // R1 words read as zero
    txn(4'b0111, BASE, 1, 0, 4'h0, 0, 0, 0);                 // R4 single full word
    txn(4'b0111, BASE + 8, 1, 0, 4'b1010, 0, 0, 0);          // R4 partial lanes
    txn(4'b0111, BASE + 8 + 3, 1, 0, 4'b0101, 0, 0, 0);      // R2 low bits ignored
    txn(4'b0110, BASE + 8, 1, 0, 4'b1111, 0, 0, 0);          // R5 enables do not mask read
    txn(4'b0111, BASE + 16, MB, 0, 4'h0, 0, 0, 0);           // R8 stop on final phase
    txn(4'b0111, BASE + 32, 6, 40, 4'h0, 1, 0, 0);           // R8 disconnect, R6 waits
    txn(4'b0111, BASE + 60, 2, 0, 4'h0, 0, 0, 0);            // R8 last word of window
    txn(4'b0110, BASE + 60, 1, 0, 4'h0, 0, 0, 0);            // R8 stop with final read
    txn(4'b0110, BASE + 24, 5, 50, 4'h0, 0, 0, 0);           // R7 increment across reads
    txn(4'b0011, BASE, 2, 0, 4'h0, 0, 0, 0);                 // R3 other command
    txn(4'b0100, BASE + 4, 2, 0, 4'h0, 0, 0, 0);             // R3 reserved command
    txn(4'b0111, BASE + 64, 2, 0, 4'h0, 0, 0, 0);            // R3 above window
    txn(4'b0111, BASE - 4, 1, 0, 4'h0, 0, 0, 0);             // R3 below window
    read_all();
    for (int t = 0; t < 80; t++) begin
      logic [3:0] cmd;
      logic [31:0] a;
      cmd = ($urandom % 10 < 8) ? (($urandom % 2) ? 4'b0111 : 4'b0110) : 4'($urandom);
      if (cmd == 4'b0110 && ($urandom % 10 == 0)) cmd = 4'b1000;
      a = ($urandom % 10 < 9) ? BASE + 32'($urandom % 64) : BASE + 32'h40 + 32'($urandom % 256);
      txn(cmd, a, 1 + int'($urandom % 6), 30, 4'h0, 1, 0, 0);
    end
    read_all();
    // R11: a flip outside checked clocks is ignored, then a data-phase flip sticks
    chk_next = 0; flip_next = 1;
    step();
    step();
    check(par_err == 1'b0, "R11 unchecked clock ignored", par_err, 0);
    txn(4'b0111, BASE + 4, 1, 0, 4'h0, 0, 0, 1);
    check(par_err == 1'b1, "R11 mismatch flagged", par_err, 1);
    repeat (5) step();
    check(par_err == 1'b1, "R11 sticky", par_err, 1);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule